// File: doc/BRIEF.md
# Software Reset Control Register

This block is a single 32-bit control register that lets software start resets. It also times the reset pulses those writes start. The register holds three live bits, and every other position is fixed at zero. The first bit asks for an internal system reset. The second drives an external reset pin for a fixed number of clocks, and software can end that pulse early. The third decides whether a checkstop request from elsewhere in the chip turns into an internal reset. Once software clears the third bit, only a power-on reset can set it again.

The register is written through a plain write strobe with 32 data bits and read back combinationally. A mode strap picks the long pulse length, used when two controllers share the reset pin. A vector of indications from the other reset sources of the chip clears the two software-reset bits. The block only produces the request and the pin level: generating, stretching and distributing the reset are done elsewhere.

Bit numbers below count from the most significant end. Bit 0 is `wrData[31]`, bit 1 is `wrData[30]` and bit 16 is `wrData[15]`.

Top module: `soft_reset_ctrl`

## Requirements
- R1: `rdData` shows the system-reset bit at [31], the external-reset bit at [30] and the checkstop-enable bit at [15]. Every other bit of `rdData` reads 0, and writes to those other positions have no effect.
- R2: A write with [31]=1 sets the system-reset bit, and `intRstReq` is 1 after the next rising edge. A write with [31]=0 clears the bit.
- R3: The system-reset bit clears on the edge where any `otherRstSrc` bit is 1, or where an enabled checkstop fires. The clear takes priority over a write in the same cycle. Starting an external reset leaves the bit set.
- R4: A write with [30]=1 while the external-reset bit is 0 makes `extRstOut` 1 from the next edge for exactly SHORT_CYCLES (2400) clocks. `intRstReq` is not affected.
- R5: If `dualMode` is 1 when the pulse starts, the pulse lasts LONG_CYCLES (16000) clocks.
- R6: The external-reset bit and `extRstOut` return to 0 when the pulse completes. They also return to 0 on the edge where any `otherRstSrc` bit is 1.
- R7: A write with [30]=0 during a pulse drops `extRstOut` and the read bit on the next edge.
- R8: The checkstop-enable bit is 1 after power-on. A write with [15]=0 clears it, and from then on writes with [15]=1 leave it at 0 until `porN` is asserted.
- R9: With checkstop enabled, `checkstopReq`=1 makes `intRstReq` 1 after the next edge. With it disabled, `checkstopReq` has no effect on `intRstReq` or on the register.
- R10: A write of 1 to the external-reset bit while a pulse runs does not lengthen the pulse. A new 0-to-1 write starts a fresh full-length pulse.
- R11: While `porN` is 0, `intRstReq` and `extRstOut` are 0 and `rdData` reads 32'h0000_8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register value |
| dualMode | input | 1 | Strap selecting the long external pulse |
| checkstopReq | input | 1 | Checkstop reset request |
| otherRstSrc | input | NUM_SRC | Other reset sources asserting |
| intRstReq | output | 1 | Internal system reset request |
| extRstOut | output | 1 | External reset pin level |

## Verification
A wrong bit state shows at `rdData` and at the two reset outputs on the very next edge after the write or the source event. The only exception is the pulse counter. A counter that is off by a few counts, that restarts on a repeated write, or that reads the mode strap at the wrong moment shows only when the pulse ends. That happens thousands of cycles later, so the bench measures whole pulse lengths exactly. A checkstop-enable bit that can be set again only shows when software writes 1 after clearing it and a checkstop then arrives.

// File: rtl/soft_reset_pkg.sv
package soft_reset_pkg;
  localparam int REG_W   = 32;
  // field positions counted from the MSB end (bit 0 = MSB)
  localparam int SYS_POS = REG_W - 1 - 0;
  localparam int EXT_POS = REG_W - 1 - 1;
  localparam int CHK_POS = REG_W - 1 - 16;

  typedef struct packed {
    logic setSys;
    logic clrSys;
    logic startExt;
    logic stopExt;
    logic clrChk;
    logic cstopFire;
  } ctrlStrb_t;
endpackage

// File: rtl/soft_reset_ctrl_fsm.sv
module soft_reset_ctrl_fsm
  import soft_reset_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               checkstopReq,
  input  logic [NUM_SRC-1:0] otherRstSrc,
  input  logic               extBit,
  input  logic               chkEn,
  output ctrlStrb_t          strb
);
  logic otherAny;
  logic otherAssert;
  logic cstopFire;
  logic unusedWrBits;

  generate
    if (NUM_SRC > 1) begin : g_multi
      assign otherAny = |otherRstSrc;
    end else begin : g_single
      assign otherAny = otherRstSrc[0];
    end
  endgenerate

  assign cstopFire    = chkEn & checkstopReq;
  assign otherAssert  = otherAny | cstopFire;
  assign unusedWrBits = ^wrData;

  always_comb begin
    strb           = '0;
    strb.cstopFire = cstopFire;
    // a clear from a reset source beats any write in the same cycle
    strb.clrSys    = otherAssert | (wrEn & ~wrData[SYS_POS]);
    strb.setSys    = wrEn & wrData[SYS_POS] & ~otherAssert;
    strb.stopExt   = otherAssert | (wrEn & ~wrData[EXT_POS]);
    strb.startExt  = wrEn & wrData[EXT_POS] & ~extBit & ~otherAssert;
    strb.clrChk    = wrEn & ~wrData[CHK_POS];
  end
endmodule

// File: rtl/soft_reset_datapath.sv
module soft_reset_datapath
  import soft_reset_pkg::*;
#(
  parameter int SHORT_CYCLES = 2400,
  parameter int LONG_CYCLES  = 16000
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             dualMode,
  input  ctrlStrb_t        strb,
  output logic             sysBit,
  output logic             extBit,
  output logic             chkEn,
  output logic             intRstReq,
  output logic             extRstOut,
  output logic [REG_W-1:0] rdData
);
  localparam int MAX_CYCLES = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);

  logic [CNT_W-1:0] pulseCnt;
  logic             longSel;
  logic             cstopHit;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = longSel ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sysBit   <= 1'b0;
      extBit   <= 1'b0;
      chkEn    <= 1'b1;
      pulseCnt <= '0;
      longSel  <= 1'b0;
      cstopHit <= 1'b0;
    end else begin
      if (strb.clrSys)      sysBit <= 1'b0;
      else if (strb.setSys) sysBit <= 1'b1;

      if (strb.stopExt) begin
        extBit   <= 1'b0;
        pulseCnt <= '0;
      end else if (strb.startExt) begin
        extBit   <= 1'b1;
        pulseCnt <= '0;
        longSel  <= dualMode;
      end else if (extBit) begin
        if (pulseCnt == lastCnt) begin
          extBit   <= 1'b0;
          pulseCnt <= '0;
        end else begin
          pulseCnt <= pulseCnt + 1'b1;
        end
      end

      if (strb.clrChk) chkEn <= 1'b0;
      cstopHit <= strb.cstopFire;
    end
  end

  assign intRstReq = sysBit | cstopHit;
  assign extRstOut = extBit;

  always_comb begin
    rdData          = '0;
    rdData[SYS_POS] = sysBit;
    rdData[EXT_POS] = extBit;
    rdData[CHK_POS] = chkEn;
  end
endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl
  import soft_reset_pkg::*;
#(
  parameter int NUM_SRC      = 4,
  parameter int SHORT_CYCLES = 2400,
  parameter int LONG_CYCLES  = 16000
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               dualMode,
  input  logic               checkstopReq,
  input  logic [NUM_SRC-1:0] otherRstSrc,
  output logic               intRstReq,
  output logic               extRstOut
);
  ctrlStrb_t strb;
  logic      sysBit;
  logic      extBit;
  logic      chkEn;
  logic      unusedSys;

  assign unusedSys = sysBit;

  soft_reset_ctrl_fsm #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .wrEn         (wrEn),
    .wrData       (wrData),
    .checkstopReq (checkstopReq),
    .otherRstSrc  (otherRstSrc),
    .extBit       (extBit),
    .chkEn        (chkEn),
    .strb         (strb)
  );

  soft_reset_datapath #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .dualMode  (dualMode),
    .strb      (strb),
    .sysBit    (sysBit),
    .extBit    (extBit),
    .chkEn     (chkEn),
    .intRstReq (intRstReq),
    .extRstOut (extRstOut),
    .rdData    (rdData)
  );
endmodule

// File: rtl/soft_reset_ctrl_chk.sv
module soft_reset_ctrl_chk
  import soft_reset_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int LONG_CYCLES = 16000
) (
  input logic               clk,
  input logic               porN,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic [NUM_SRC-1:0] otherRstSrc,
  input logic               intRstReq,
  input logic               extRstOut
);
  localparam int HW = $clog2(LONG_CYCLES + 2);
  localparam logic [REG_W-1:0] LIVE =
    (REG_W'(1) << SYS_POS) | (REG_W'(1) << EXT_POS) | (REG_W'(1) << CHK_POS);

  logic [HW-1:0] hiCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)          hiCnt <= '0;
    else if (extRstOut) hiCnt <= hiCnt + 1'b1;
    else                hiCnt <= '0;
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!porN)
    (rdData & ~LIVE) == '0);

  assert_src_clears_R3: assert property (@(posedge clk) disable iff (!porN)
    (|otherRstSrc) |=> (!rdData[SYS_POS] && !rdData[EXT_POS] && !extRstOut));

  assert_ext_needs_write_R4: assert property (@(posedge clk) disable iff (!porN)
    !extRstOut ##1 extRstOut |-> $past(wrEn && wrData[EXT_POS]));

  assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!porN)
    extRstOut |-> (hiCnt < HW'(LONG_CYCLES)));

  assert_chk_no_rise_R8: assert property (@(posedge clk) disable iff (!porN)
    !rdData[CHK_POS] |=> !rdData[CHK_POS]);

  assert_cstop_ignored_R9: assert property (@(posedge clk) disable iff (!porN)
    (!rdData[CHK_POS] && !rdData[SYS_POS] && !(wrEn && wrData[SYS_POS])) |=> !intRstReq);
endmodule

bind soft_reset_ctrl soft_reset_ctrl_chk #(
  .NUM_SRC     (NUM_SRC),
  .LONG_CYCLES (LONG_CYCLES)
) u_chk (
  .clk         (clk),
  .porN        (porN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .otherRstSrc (otherRstSrc),
  .intRstReq   (intRstReq),
  .extRstOut   (extRstOut)
);

// File: tb/tb_soft_reset_ctrl.sv
`timescale 1ns/1ps
module tb_soft_reset_ctrl;
  localparam logic [31:0] SYS = 32'h8000_0000;
  localparam logic [31:0] EXT = 32'h4000_0000;
  localparam logic [31:0] CHK = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        dualMode = 1'b0;
  logic        checkstopReq = 1'b0;
  logic [3:0]  otherRstSrc = '0;
  logic        intRstReq;
  logic        extRstOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  soft_reset_ctrl dut (
    .clk(clk), .porN(porN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .dualMode(dualMode), .checkstopReq(checkstopReq), .otherRstSrc(otherRstSrc),
    .intRstReq(intRstReq), .extRstOut(extRstOut)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic [3:0]  other;
    logic        cs;
    logic [31:0] expRd;
    logic        expInt;
    logic        expExt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, SYS | CHK,       4'h0, 1'b0, SYS | CHK,       1'b1, 1'b0}, // R2 set
    '{1'b1, SYS | EXT | CHK, 4'h0, 1'b0, SYS | EXT | CHK, 1'b1, 1'b1}, // R3 ext leaves sys
    '{1'b0, 32'h0,           4'h1, 1'b0, CHK,             1'b0, 1'b0}, // R3/R6 source clears
    '{1'b1, 32'hFFFF_FFFF,   4'h0, 1'b0, SYS | EXT | CHK, 1'b1, 1'b1}, // R1 reserved ignored
    '{1'b1, SYS | CHK,       4'h0, 1'b0, SYS | CHK,       1'b1, 1'b0}, // R7 early stop
    '{1'b1, 32'h0,           4'h0, 1'b0, 32'h0,           1'b0, 1'b0}, // R8 clear / R2 clear
    '{1'b1, CHK,             4'h0, 1'b0, 32'h0,           1'b0, 1'b0}, // R8 stays clear
    '{1'b0, 32'h0,           4'h0, 1'b1, 32'h0,           1'b0, 1'b0}  // R9 ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; wrData = '0; otherRstSrc = '0; checkstopReq = 1'b0;
  endtask

  // drive at a negedge, return at the next negedge (one rising edge later)
  task automatic cycle(input logic wr, input logic [31:0] d, input logic [3:0] o, input logic cs);
    wrEn = wr; wrData = d; otherRstSrc = o; checkstopReq = cs;
    @(negedge clk);
    idle();
  endtask

  task automatic por();
    porN = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
  endtask

  // count negedge samples with extRstOut high, starting at the current negedge
  task automatic measure(output int n);
    n = 0;
    while (extRstOut && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    @(negedge clk);
    check("R11 rd in reset", rdData, CHK);
    check("R11 int in reset", {31'b0, intRstReq}, 32'd0);
    check("R11 ext in reset", {31'b0, extRstOut}, 32'd0);
    porN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].wr, VECS[i].data, VECS[i].other, VECS[i].cs);
      check($sformatf("R1 vec%0d rd", i), rdData, VECS[i].expRd);
      check($sformatf("R2 vec%0d int", i), {31'b0, intRstReq}, {31'b0, VECS[i].expInt});
      check($sformatf("R4 vec%0d ext", i), {31'b0, extRstOut}, {31'b0, VECS[i].expExt});
    end

    // R8: power-on brings checkstop enable back
    por();
    check("R8 chk restored", rdData, CHK);

    // R9 / R3: enabled checkstop fires and clears the system bit
    cycle(1'b1, SYS | CHK, 4'h0, 1'b0);
    cycle(1'b0, 32'h0, 4'h0, 1'b1);
    check("R9 cstop int", {31'b0, intRstReq}, 32'd1);
    check("R3 cstop clears sys", rdData, CHK);
    @(negedge clk);
    check("R9 cstop released", {31'b0, intRstReq}, 32'd0);

    // R3: source clear beats a same-cycle write
    cycle(1'b1, SYS | EXT | CHK, 4'h8, 1'b0);
    check("R3 clear beats write rd", rdData, CHK);
    check("R3 clear beats write ext", {31'b0, extRstOut}, 32'd0);

    // R4 / R6: short pulse length, no internal reset
    cycle(1'b1, EXT | CHK, 4'h0, 1'b0);
    check("R4 int low during pulse", {31'b0, intRstReq}, 32'd0);
    measure(len);
    check("R4 short length", len, 32'd2400);
    check("R6 bit clears at end", rdData, CHK);

    // R5: long pulse with dual mode, strap sampled at start
    dualMode = 1'b1;
    cycle(1'b1, EXT | CHK, 4'h0, 1'b0);
    dualMode = 1'b0;
    measure(len);
    check("R5 long length", len, 32'd16000);

    // R10: rewrite of 1 mid-pulse does not extend
    cycle(1'b1, EXT | CHK, 4'h0, 1'b0);
    repeat (99) @(negedge clk);
    cycle(1'b1, EXT | CHK, 4'h0, 1'b0);
    measure(len);
    check("R10 rewrite no extend", len + 100, 32'd2400);

    // R7 then R10: cancel then fresh start gets full length
    cycle(1'b1, EXT | CHK, 4'h0, 1'b0);
    repeat (49) @(negedge clk);
    cycle(1'b1, CHK, 4'h0, 1'b0);
    check("R7 cancel drops pin", {31'b0, extRstOut}, 32'd0);
    cycle(1'b1, EXT | CHK, 4'h0, 1'b0);
    measure(len);
    check("R10 fresh full length", len, 32'd2400);

    // R11: power-on reset in the middle of a pulse
    cycle(1'b1, SYS | EXT | CHK, 4'h0, 1'b0);
    porN = 1'b0;
    #1;
    check("R11 por drops ext", {31'b0, extRstOut}, 32'd0);
    check("R11 por drops int", {31'b0, intRstReq}, 32'd0);
    check("R11 por rd", rdData, CHK);
    porN = 1'b1;

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule